// File: doc/BRIEF.md
# Dual Serial Flash Connection Router

The router sits between a serial flash controller core that drives one chip select and one four-line data bus, and a pair of identical external serial flash devices. A configuration word picks one of three wirings. In single mode only the lower device is used. In stacked mode both devices share the clock and the data lines, and a page bit chooses which one receives the chip select. In parallel mode the two devices are selected together, each on its own bus. Each core data byte is split by bit parity, with even bits going to the lower bus and odd bits to the upper bus, and read data is woven back into bytes the same way.

Because the two devices are identical, one address stream serves both, and the router never looks at command or address content. The core provides only one chip select, and the router makes the second one whenever two-device operation is enabled. The configuration register changes only while the core's chip select is high. A configuration write that arrives during a transfer is held and takes effect once the transfer ends. All pins are plain level signals that follow the serial clock domain of the core. The pins carry no valid/ready stream because the data lanes move one beat per serial clock, with no back-pressure.

Top module: `dflash_router`

## Requirements
- R1: After reset the router is in single mode with the page bit clear. Whenever `core_cs_n` is high, both `lo_cs_n` and `up_cs_n` are high.
- R2: Configuration word bit 30 clear selects single mode. In this mode `lo_cs_n` follows `core_cs_n` and `up_cs_n` stays high. `lo_io_out` carries `core_dout[3:0]`, `core_din` is `{4'b0, lo_io_in}`, and `up_sck` is held low while `lo_sck` follows `core_sck`.
- R3: With bit 30 set, bit 29 clear and bit 28 (page) clear, stacked mode targets the lower device. `lo_cs_n` follows `core_cs_n` and `up_cs_n` stays high. Data is routed as in R2, and both serial clocks follow `core_sck`.
- R4: With bits 30 and 28 set and bit 29 clear, stacked mode targets the upper device. `up_cs_n` follows `core_cs_n` and `lo_cs_n` stays high. `up_io_out` carries `core_dout[3:0]` and `core_din` is `{4'b0, up_io_in}`.
- R5: With bits 30 and 29 set, parallel mode is active. Both `lo_cs_n` and `up_cs_n` follow `core_cs_n`, both clocks follow `core_sck`, and bit 28 has no effect.
- R6: In parallel mode, `lo_io_out[i]` equals `core_dout[2i]` and `up_io_out[i]` equals `core_dout[2i+1]`, for i from 0 to 3, in the same cycle.
- R7: In parallel mode, `core_din[2i]` equals `lo_io_in[i]` and `core_din[2i+1]` equals `up_io_in[i]`.
- R8: On each bus in use, every output-enable bit equals `core_oe`. A bus not in use in the current mode has its output enables and its output data at zero.
- R9: A configuration write made while `core_cs_n` is low leaves the routing unchanged until `core_cs_n` goes high. When several such writes are made, the last one is applied at the first clock edge that sees `core_cs_n` high.
- R10: A configuration write made while `core_cs_n` is high takes effect at that same clock edge.
- R11: Configuration bits other than 30, 29 and 28 have no effect. Bit 29 has no effect while bit 30 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration word (bits 30, 29, 28 used) |
| core_cs_n | input | 1 | Chip select from the controller core, active low |
| core_sck | input | 1 | Serial clock from the core |
| core_oe | input | 1 | Core data direction, 1 = drive towards flash |
| core_dout | input | 8 | Core outgoing data lanes (low four used unless parallel) |
| core_din | output | 8 | Incoming data lanes to the core |
| lo_cs_n | output | 1 | Lower device chip select, active low |
| lo_sck | output | 1 | Lower device serial clock |
| lo_io_out | output | 4 | Lower bus output data |
| lo_io_oe | output | 4 | Lower bus output enables |
| lo_io_in | input | 4 | Lower bus input data |
| up_cs_n | output | 1 | Upper device chip select, active low |
| up_sck | output | 1 | Upper device serial clock |
| up_io_out | output | 4 | Upper bus output data |
| up_io_oe | output | 4 | Upper bus output enables |
| up_io_in | input | 4 | Upper bus input data |

## Verification
The only state in the router is the active mode, the page bit and a held pending write. A wrong value in any of them shows up on the first pin cycle after it takes hold. It appears as a chip select on the wrong device, two selects active outside parallel mode, bits landing in the wrong parity slot, or drivers enabled on an idle bus. The bench sweeps every mode and page setting against every byte value, with junk set in the unused configuration bits. It also exercises writes that are held during a transfer and released when it ends, so that a wrongly updated or wrongly held register is caught within a cycle of the next transfer.

// File: rtl/dflash_pkg.sv
package dflash_pkg;
  localparam int CFG_W        = 32;
  localparam int TWO_DEV_BIT  = 30;
  localparam int SPLIT_BIT    = 29;
  localparam int PAGE_BIT     = 28;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_STACKED  = 2'd1,
    MODE_PARALLEL = 2'd2
  } conn_mode_e;

  typedef struct packed {
    conn_mode_e mode;
    logic       upper_pg;
  } conn_cfg_t;

  localparam conn_cfg_t CFG_RESET = '{mode: MODE_SINGLE, upper_pg: 1'b0};

  function automatic conn_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    conn_cfg_t c;
    if (!w[TWO_DEV_BIT])   c.mode = MODE_SINGLE;
    else if (w[SPLIT_BIT]) c.mode = MODE_PARALLEL;
    else                   c.mode = MODE_STACKED;
    c.upper_pg = w[PAGE_BIT];
    return c;
  endfunction
endpackage

// File: rtl/dflash_cfg.sv
module dflash_cfg
  import dflash_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_cs_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output conn_cfg_t        cfg_q
);
  conn_cfg_t pend_val;
  logic      pend_q;
  conn_cfg_t wr_dec;

  assign wr_dec = decode_cfg(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RESET;
      pend_val <= CFG_RESET;
      pend_q   <= 1'b0;
    end else if (core_cs_n) begin
      if (wr_en)       cfg_q <= wr_dec;
      else if (pend_q) cfg_q <= pend_val;
      pend_q <= 1'b0;
    end else if (wr_en) begin
      pend_val <= wr_dec;
      pend_q   <= 1'b1;
    end
  end

  // R9: routing never changes across an edge that saw a transfer in progress
  assert_cfg_frozen_in_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_cs_n |=> $stable(cfg_q));

  // R9: any held write is consumed at the first idle edge
  assert_pend_drained_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_cs_n |=> !pend_q);
endmodule

// File: rtl/dflash_cs_steer.sv
module dflash_cs_steer
  import dflash_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  conn_cfg_t cfg,
  input  logic      core_cs_n,
  input  logic      core_sck,
  output logic      lo_cs_n,
  output logic      up_cs_n,
  output logic      lo_sck,
  output logic      up_sck,
  output logic      lo_act,
  output logic      up_act
);
  logic two_dev, par, stk;

  always_comb begin
    two_dev = (cfg.mode != MODE_SINGLE);
    par     = (cfg.mode == MODE_PARALLEL);
    stk     = (cfg.mode == MODE_STACKED);
    lo_act  = !two_dev || par || !cfg.upper_pg;
    up_act  = par || (stk && cfg.upper_pg);
    lo_cs_n = core_cs_n | ~lo_act;
    up_cs_n = core_cs_n | ~up_act;
    lo_sck  = core_sck;
    up_sck  = core_sck & two_dev;
  end

  // R3 / R4: outside parallel mode at most one device is selected
  assert_single_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode != MODE_PARALLEL) |-> (lo_cs_n || up_cs_n));

  // R1: an idle core leaves both devices deselected
  assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_cs_n |-> (lo_cs_n && up_cs_n));
endmodule

// File: rtl/dflash_lane_mux.sv
module dflash_lane_mux
  import dflash_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CW   = 2 * LANES
)(
  input  logic             clk,
  input  logic             rst_n,
  input  conn_cfg_t        cfg,
  input  logic             lo_act,
  input  logic             up_act,
  input  logic             core_oe,
  input  logic [CW-1:0]    core_dout,
  output logic [CW-1:0]    core_din,
  output logic [LANES-1:0] lo_io_out,
  output logic [LANES-1:0] lo_io_oe,
  input  logic [LANES-1:0] lo_io_in,
  output logic [LANES-1:0] up_io_out,
  output logic [LANES-1:0] up_io_oe,
  input  logic [LANES-1:0] up_io_in
);
  logic [LANES-1:0] even_d, odd_d;
  logic [CW-1:0]    woven;
  logic             par;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign even_d[i]      = core_dout[2*i];
    assign odd_d[i]       = core_dout[2*i+1];
    assign woven[2*i]     = lo_io_in[i];
    assign woven[2*i+1]   = up_io_in[i];
  end

  always_comb begin
    par       = (cfg.mode == MODE_PARALLEL);
    lo_io_out = !lo_act ? '0 : (par ? even_d : core_dout[LANES-1:0]);
    up_io_out = !up_act ? '0 : (par ? odd_d  : core_dout[LANES-1:0]);
    lo_io_oe  = lo_act ? {LANES{core_oe}} : '0;
    up_io_oe  = up_act ? {LANES{core_oe}} : '0;
    if (par)         core_din = woven;
    else if (up_act) core_din = {{LANES{1'b0}}, up_io_in};
    else             core_din = {{LANES{1'b0}}, lo_io_in};
  end

  // R8: an unused bus is quiet
  assert_idle_upper_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !up_act |-> (up_io_oe == '0 && up_io_out == '0));
  assert_idle_lower_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_act |-> (lo_io_oe == '0 && lo_io_out == '0));
  // R8: a parallel transfer drives both buses together
  assert_par_both_buses_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par |-> (lo_io_oe == up_io_oe));
endmodule

// File: rtl/dflash_router.sv
module dflash_router
  import dflash_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CW   = 2 * LANES
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  input  logic             core_cs_n,
  input  logic             core_sck,
  input  logic             core_oe,
  input  logic [CW-1:0]    core_dout,
  output logic [CW-1:0]    core_din,
  output logic             lo_cs_n,
  output logic             lo_sck,
  output logic [LANES-1:0] lo_io_out,
  output logic [LANES-1:0] lo_io_oe,
  input  logic [LANES-1:0] lo_io_in,
  output logic             up_cs_n,
  output logic             up_sck,
  output logic [LANES-1:0] up_io_out,
  output logic [LANES-1:0] up_io_oe,
  input  logic [LANES-1:0] up_io_in
);
  conn_cfg_t cfg_q;
  logic      lo_act, up_act;

  dflash_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .core_cs_n(core_cs_n),
    .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .cfg_q(cfg_q)
  );

  dflash_cs_steer u_steer (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q),
    .core_cs_n(core_cs_n), .core_sck(core_sck),
    .lo_cs_n(lo_cs_n), .up_cs_n(up_cs_n),
    .lo_sck(lo_sck), .up_sck(up_sck),
    .lo_act(lo_act), .up_act(up_act)
  );

  dflash_lane_mux #(.LANES(LANES)) u_lanes (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q),
    .lo_act(lo_act), .up_act(up_act),
    .core_oe(core_oe), .core_dout(core_dout), .core_din(core_din),
    .lo_io_out(lo_io_out), .lo_io_oe(lo_io_oe), .lo_io_in(lo_io_in),
    .up_io_out(up_io_out), .up_io_oe(up_io_oe), .up_io_in(up_io_in)
  );
endmodule

// File: tb/dflash_router_bench.sv
module dflash_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic        core_cs_n = 1'b1, core_sck = 1'b0, core_oe = 1'b0;
  logic [7:0]  core_dout = '0, core_din;
  logic        lo_cs_n, lo_sck, up_cs_n, up_sck;
  logic [3:0]  lo_io_out, lo_io_oe, lo_io_in = '0;
  logic [3:0]  up_io_out, up_io_oe, up_io_in = '0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  dflash_router u_dflash_router (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .core_cs_n(core_cs_n), .core_sck(core_sck), .core_oe(core_oe),
    .core_dout(core_dout), .core_din(core_din),
    .lo_cs_n(lo_cs_n), .lo_sck(lo_sck), .lo_io_out(lo_io_out),
    .lo_io_oe(lo_io_oe), .lo_io_in(lo_io_in),
    .up_cs_n(up_cs_n), .up_sck(up_sck), .up_io_out(up_io_out),
    .up_io_oe(up_io_oe), .up_io_in(up_io_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pick(input logic [7:0] d, input int ofs);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (d >> (2 * i + ofs)) & 8'h1;
    return r;
  endfunction

  function automatic logic [7:0] weave(input logic [3:0] a, input logic [3:0] b);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r[2*i]   = a[i];
      r[2*i+1] = b[i];
    end
    return r;
  endfunction

  // Junk in every configuration bit except 30..28 (R11)
  task automatic write_cfg(input logic [2:0] m);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = (32'h8F5A_C3E9 & ~32'h7000_0000) | ({29'd0, m} << 28);
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state, single mode
    core_cs_n = 1'b0;
    #5;
    chk("R1 reset selects", {30'd0, lo_cs_n, up_cs_n}, 32'b01);
    core_cs_n = 1'b1;
    #1;
    chk("R1 idle deselects", {30'd0, lo_cs_n, up_cs_n}, 32'b11);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // Sweep modes x cs x oe x data
    for (int m = 0; m < 8; m++) begin
      logic two, par, pg, loa, upa;
      string tg;
      write_cfg(m[2:0]);
      two = m[2]; par = m[2] & m[1]; pg = m[0];
      loa = !two || par || !pg;
      upa = par || (two && !par && pg);
      tg = !two ? (m[1] ? "R11" : "R2") : par ? "R5" : pg ? "R4" : "R3";
      for (int cs = 0; cs < 2; cs++) begin
        for (int oe = 0; oe < 2; oe++) begin
          for (int d = 0; d < 256; d++) begin
            logic [7:0] dv;
            logic [3:0] eo, eu;
            logic [7:0] ed;
            dv = d[7:0];
            core_cs_n = cs[0]; core_oe = oe[0]; core_dout = dv;
            core_sck = dv[0]; lo_io_in = dv[7:4] ^ 4'h9; up_io_in = dv[3:0] ^ 4'h6;
            #2;
            chk({tg, " selects/clocks"},
                {28'd0, lo_cs_n, up_cs_n, lo_sck, up_sck},
                {28'd0, cs[0] | ~loa, cs[0] | ~upa, dv[0], dv[0] & two});
            eo = !loa ? 4'h0 : par ? pick(dv, 0) : dv[3:0];
            eu = !upa ? 4'h0 : par ? pick(dv, 1) : dv[3:0];
            chk(par ? "R6 split out" : {tg, " data out"},
                {24'd0, lo_io_out, up_io_out}, {24'd0, eo, eu});
            chk("R8 output enables", {24'd0, lo_io_oe, up_io_oe},
                {24'd0, loa ? {4{oe[0]}} : 4'h0, upa ? {4{oe[0]}} : 4'h0});
            ed = par ? weave(lo_io_in, up_io_in) : upa ? {4'h0, up_io_in} : {4'h0, lo_io_in};
            chk(par ? "R7 weave in" : {tg, " data in"}, {24'd0, core_din}, {24'd0, ed});
          end
        end
      end
    end

    // R10: idle write takes effect at the write edge
    core_cs_n = 1'b1;
    write_cfg(3'b000);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 32'h5000_0000;  // stacked, upper page
    core_cs_n = 1'b0;
    #2;
    chk("R10 before edge", {30'd0, lo_cs_n, up_cs_n}, 32'b01);
    core_cs_n = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0; core_cs_n = 1'b0;
    #2;
    chk("R10 after edge", {30'd0, lo_cs_n, up_cs_n}, 32'b10);

    // R9: writes during a transfer are held; last one wins
    core_cs_n = 1'b1;
    write_cfg(3'b110);                // parallel
    core_cs_n = 1'b0;
    write_cfg(3'b101);                // stacked upper, held
    write_cfg(3'b100);                // stacked lower, held, latest
    @(negedge clk);
    chk("R9 held during transfer", {30'd0, lo_cs_n, up_cs_n}, 32'b00);
    core_cs_n = 1'b1;
    @(negedge clk);
    core_cs_n = 1'b0;
    #2;
    chk("R9 applied after transfer", {30'd0, lo_cs_n, up_cs_n}, 32'b01);
    core_cs_n = 1'b1;
    @(negedge clk);
    core_cs_n = 1'b0;
    #2;
    chk("R9 stays applied", {30'd0, lo_cs_n, up_cs_n}, 32'b01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule